// File: doc/BRIEF.md
# SPI Register Access Slave

This block is the serial front end of a sensor's register file. A host talks to it over a four-wire SPI link in mode 3 (clock idles high, input sampled on the rising edge, output changed on the falling edge), most significant bit first, in frames of 16 bits. Each frame holds a write flag, a 7-bit byte address and one data byte. Registers are 16 bits wide and take two byte addresses each. A write frame changes one byte. A read frame only names a register, and the whole 16-bit word comes back during the next frame, which may itself carry the next read request.

All serial pins are brought into the system clock domain through two-flop synchronisers, and edges are detected there, so the system clock must run at least eight times faster than SCLK. Toward the register bank the block gives a one-cycle byte-write strobe with address and data, and a word address whose read data it loads into its transmit shifter. A read of any of the capture-buffer window words also pulses an advance strobe for the shared sample index. Two sticky flags report faults. One is set when a chip-select-low period ends with an SCLK count that is not a multiple of 16. The other is set when a write lands while a capture is running.

Top module: `spi_reg_slave`

## Requirements
- R1: MOSI is sampled on SCLK rising edges and MISO changes only after SCLK falling edges, most significant bit first, so a host sampling MISO just before each rising edge receives the response word in bit order 15 down to 0.
- R2: A frame decodes as bit 15 = write flag (1 = write, 0 = read), bits 14:8 = byte address, bits 7:0 = data byte. The data byte is ignored for reads.
- R3: After the 16th rising edge of a frame, with chip select still low, a write frame produces exactly one cycle of `wr_stb_o`, carrying the frame's byte address on `wr_addr_o` and its data byte on `wr_data_o`. Bit 0 of the byte address selects the high byte (1) or the low byte (0) of word `addr[6:1]`.
- R4: A read frame presents word address `addr[6:1]` on `rd_addr_o`. The `rd_data_i` word is shifted out on MISO during the next frame, and the odd and the even byte address of a word both return the full word.
- R5: The frame after a write frame, and the first frame after reset, shift out all zeros.
- R6: `miso_oe_o` is 0 whenever `cs_ni` is high and 1 whenever `cs_ni` is low.
- R7: When chip select rises after a number of SCLK rising edges that is not a multiple of 16, `comm_err_o` goes to 1 and stays there until reset. The incomplete frame writes nothing. Several whole frames under one chip-select-low period are all executed and do not set the flag.
- R8: A read frame whose word address lies in the capture window (words BUF_BASE to BUF_BASE+BUF_CNT-1, byte addresses 0x14 to 0x19 by default) pulses `buf_adv_o` for one cycle. The data returned for it is the sample before the advance. Reads outside the window and all writes do not pulse it.
- R9: A write strobe while `capture_busy_i` is 1 sets `capt_int_o`, which stays 1 until reset. Reads never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles high |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| wr_stb_o | output | 1 | One-cycle byte write strobe |
| wr_addr_o | output | 7 | Byte address of the write |
| wr_data_o | output | 8 | Byte to write |
| rd_addr_o | output | 6 | Word address of the pending read |
| rd_data_i | input | 16 | Word at `rd_addr_o` from the register bank |
| buf_adv_o | output | 1 | One-cycle capture-index advance strobe |
| capture_busy_i | input | 1 | A capture is in progress |
| comm_err_o | output | 1 | Sticky frame-length error |
| capt_int_o | output | 1 | Sticky write-during-capture flag |

## Verification
The hardest situation to reach from the ports is a chip-select-low period that is not a multiple of 16 edges. The bench uses a transfer task that takes a bit count, sends a 7-edge fragment that would otherwise have been a write, and confirms that the flag is set, that no strobe appeared and that the target word still reads back unchanged. The same task also sends 32 edges under one chip select, to show that two whole frames are both executed without an error. The window advance is checked by chaining reads across the three window words and back, so that each returned word has to carry the index value counted by the bench before that read.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 7;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int WADDR_W = ADDR_W - 1;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= d_i;
      else             stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_regs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sclk_s_i,
  input  logic   cs_s_i,
  input  logic   din_s_i,
  output logic   done_o,
  output frame_t frame_o,
  output logic   fall_o,
  output logic   bad_len_o
);
  logic               sclk_q, cs_q;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-2:0] sr;
  logic               rise;

  assign rise   = sclk_s_i & ~sclk_q & ~cs_s_i;
  assign fall_o = ~sclk_s_i & sclk_q & ~cs_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b1;
      cs_q      <= 1'b1;
      cnt       <= '0;
      sr        <= '0;
      frame_o   <= '0;
      done_o    <= 1'b0;
      bad_len_o <= 1'b0;
    end else begin
      sclk_q    <= sclk_s_i;
      cs_q      <= cs_s_i;
      done_o    <= 1'b0;
      // cs rising edge with a partial frame pending
      bad_len_o <= cs_s_i & ~cs_q & (cnt != '0);
      if (cs_s_i) begin
        cnt <= '0;
      end else if (rise) begin
        sr  <= {sr[FRAME_W-3:0], din_s_i};
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(FRAME_W-1)) begin
          frame_o <= frame_t'({sr, din_s_i});
          done_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_tx.sv
module spi_tx
  import spi_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_val_i,
  input  logic              shift_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr    <= '0;
      bit_o <= 1'b0;
    end else if (load_i) begin
      sr <= load_val_i;
    end else if (shift_i) begin
      bit_o <= sr[WORD_W-1];
      sr    <= {sr[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_regs_pkg::*;
#(
  parameter int BUF_BASE = 10,
  parameter int BUF_CNT  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        cs_ni,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        miso_oe_o,
  output logic        wr_stb_o,
  output logic [6:0]  wr_addr_o,
  output logic [7:0]  wr_data_o,
  output logic [5:0]  rd_addr_o,
  input  logic [15:0] rd_data_i,
  output logic        buf_adv_o,
  input  logic        capture_busy_i,
  output logic        comm_err_o,
  output logic        capt_int_o
);
  localparam logic [WADDR_W:0] WIN_LO = (WADDR_W+1)'(BUF_BASE);
  localparam logic [WADDR_W:0] WIN_HI = (WADDR_W+1)'(BUF_BASE + BUF_CNT);

  logic       cs_s, sclk_s, din_s;
  logic       done, fall, bad_len, in_win;
  frame_t     frm;
  logic [WADDR_W-1:0] waddr;

  spi_sync #(.W(3), .STAGES(2), .RST_VAL(3'b110)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, mosi_i}),
    .q_o    ({cs_s, sclk_s, din_s})
  );

  spi_frame_rx u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (sclk_s),
    .cs_s_i    (cs_s),
    .din_s_i   (din_s),
    .done_o    (done),
    .frame_o   (frm),
    .fall_o    (fall),
    .bad_len_o (bad_len)
  );

  assign waddr  = frm.addr[ADDR_W-1:1];
  assign in_win = ({1'b0, waddr} >= WIN_LO) && ({1'b0, waddr} < WIN_HI);

  assign wr_stb_o  = done & frm.wr;
  assign wr_addr_o = frm.addr;
  assign wr_data_o = frm.data;
  assign rd_addr_o = waddr;
  assign buf_adv_o = done & ~frm.wr & in_win;
  assign miso_oe_o = ~cs_ni;

  // word is captured in the same cycle as the index advance: pre-advance sample
  spi_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (done),
    .load_val_i (frm.wr ? '0 : rd_data_i),
    .shift_i    (fall),
    .bit_o      (miso_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comm_err_o <= 1'b0;
      capt_int_o <= 1'b0;
    end else begin
      if (bad_len)                     comm_err_o <= 1'b1;
      if (wr_stb_o && capture_busy_i)  capt_int_o <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_stb_o,
  input logic buf_adv_o,
  input logic capture_busy_i,
  input logic comm_err_o,
  input logic capt_int_o
);
  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_stb_o |=> !wr_stb_o); // R3
  AST_ADV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) buf_adv_o |=> !buf_adv_o); // R8
  AST_ADV_NOT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0({wr_stb_o, buf_adv_o})); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) comm_err_o |=> comm_err_o); // R7
  AST_CAPT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) (wr_stb_o && capture_busy_i) |=> capt_int_o); // R9
  AST_CAPT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) capt_int_o |=> capt_int_o); // R9
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_stb_o       (wr_stb_o),
  .buf_adv_o      (buf_adv_o),
  .capture_busy_i (capture_busy_i),
  .comm_err_o     (comm_err_o),
  .capt_int_o     (capt_int_o)
);

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WIN_BASE   = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, miso_oe, wr_stb, buf_adv, busy = 1'b0, comm_err, capt_int;
  logic [6:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [5:0]  rd_addr;
  logic [15:0] rd_data;

  int n_chk = 0, n_bad = 0, n_stb = 0;
  bit finished = 0;

  logic [15:0] mem     [64];
  logic [15:0] exp_mem [64];
  logic [9:0]  idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .buf_adv_o(buf_adv), .capture_busy_i(busy), .comm_err_o(comm_err),
    .capt_int_o(capt_int)
  );

  function automatic logic [15:0] win_val(int k, logic [9:0] i);
    return 16'((k + 1) << 12) | 16'(i);
  endfunction

  // register bank model
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) idx <= '0;
    else begin
      if (wr_stb) begin
        if (wr_addr[0]) mem[wr_addr[6:1]][15:8] <= wr_data;
        else            mem[wr_addr[6:1]][7:0]  <= wr_data;
        n_stb <= n_stb + 1;
      end
      if (buf_adv) idx <= idx + 1'b1;
    end
  end

  always_comb begin
    if (int'(rd_addr) >= WIN_BASE && int'(rd_addr) < WIN_BASE + 3)
      rd_data = win_val(int'(rd_addr) - WIN_BASE, idx);
    else
      rd_data = mem[rd_addr];
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // nbits sent from bit nbits-1 down; last 16 bits of MISO returned
  task automatic xfer(input logic [31:0] mo, input int nbits, output logic [15:0] mi);
    mi = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = mo[nbits-1-i];
      repeat (HALF) @(negedge clk);
      mi = {mi[14:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [6:0] a, input logic [7:0] d);
    logic [15:0] r;
    xfer({16'h0, 1'b1, a, d}, 16, r);
    if (a[0]) exp_mem[a[6:1]][15:8] = d;
    else      exp_mem[a[6:1]][7:0]  = d;
  endtask

  task automatic rd_req(input logic [6:0] a, output logic [15:0] r);
    xfer({16'h0, 1'b0, a, 8'hA5}, 16, r);
  endtask

  initial begin
    logic [15:0] r;
    int prev, s0, k;
    for (int i = 0; i < 64; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    do_reset();

    chk("R6 reset oe", 16'(miso_oe), 16'h0);
    chk("R7 reset err", 16'(comm_err), 16'h0);
    chk("R9 reset capt", 16'(capt_int), 16'h0);
    chk("R3 reset strobes", 16'(n_stb), 16'h0);

    // R6 enable follows chip select
    cs_n = 1'b0; repeat (4) @(negedge clk);
    chk("R6 oe with cs low", 16'(miso_oe), 16'h1);
    cs_n = 1'b1; repeat (4) @(negedge clk);
    chk("R6 oe with cs high", 16'(miso_oe), 16'h0);

    // R5 first frame after reset returns zero
    rd_req(7'h00, r);
    chk("R5 first frame zero", r, 16'h0);

    // R2 R3 byte writes across all non-window words
    for (int w = 0; w < 32; w++) begin
      if (w >= WIN_BASE && w < WIN_BASE + 3) continue;
      wr_byte(7'(2*w), 8'(w*7 + 3));
      wr_byte(7'(2*w+1), 8'(w*13 + 8'h50));
    end
    chk("R3 strobe count", 16'(n_stb), 16'(2*29));

    // R4 R1 chained reads, alternating even and odd byte addresses
    rd_req(7'h00, r);
    prev = 0;
    for (int w = 1; w < 32; w++) begin
      if (w >= WIN_BASE && w < WIN_BASE + 3) continue;
      rd_req(7'(2*w + (w & 1)), r);
      chk("R4 pipelined read", r, exp_mem[prev]);
      prev = w;
    end
    rd_req(7'h00, r);
    chk("R4 last read", r, exp_mem[prev]);
    chk("R2 read data byte ignored", 16'(n_stb), 16'(2*29));

    // R3 single byte update leaves the other byte
    wr_byte(7'h05, 8'hC3);
    rd_req(7'h04, r);
    chk("R5 frame after write zero", r, 16'h0);
    rd_req(7'h00, r);
    chk("R3 high byte only", r, exp_mem[2]);

    // R8 window advance
    s0 = int'(idx);
    rd_req(7'h14, r);
    rd_req(7'h16, r);
    chk("R8 BUF0 pre-advance", r, win_val(0, 10'(s0)));
    rd_req(7'h19, r);
    chk("R8 BUF1", r, win_val(1, 10'(s0 + 1)));
    rd_req(7'h15, r);
    chk("R8 BUF2", r, win_val(2, 10'(s0 + 2)));
    rd_req(7'h02, r);
    chk("R8 BUF0 again", r, win_val(0, 10'(s0 + 3)));
    rd_req(7'h02, r);
    chk("R8 non-window no advance", 16'(idx), 16'(s0 + 4));
    wr_byte(7'h14, 8'h77);
    chk("R8 write no advance", 16'(idx), 16'(s0 + 4));

    // R7 partial frame
    k = n_stb;
    xfer({16'h0, 1'b1, 7'h06, 8'hEE}, 7, r);
    chk("R7 error set", 16'(comm_err), 16'h1);
    chk("R7 no write", 16'(n_stb), 16'(k));
    rd_req(7'h06, r);
    rd_req(7'h00, r);
    chk("R7 word unchanged", r, exp_mem[3]);
    chk("R7 sticky", 16'(comm_err), 16'h1);

    // R7 two frames under one chip select
    do_reset();
    xfer({1'b1, 7'h08, 8'h3C, 1'b1, 7'h09, 8'hC5}, 32, r);
    exp_mem[4] = 16'hC53C;
    chk("R7 no error on 32 edges", 16'(comm_err), 16'h0);
    rd_req(7'h08, r);
    rd_req(7'h00, r);
    chk("R7 both frames written", r, exp_mem[4]);

    // R9 write during capture
    do_reset();
    busy = 1'b1;
    rd_req(7'h00, r);
    chk("R9 read no flag", 16'(capt_int), 16'h0);
    wr_byte(7'h0A, 8'h11);
    chk("R9 write sets flag", 16'(capt_int), 16'h1);
    busy = 1'b0;
    rd_req(7'h00, r);
    chk("R9 flag sticky", 16'(capt_int), 16'h1);

    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule